// File: doc/BRIEF.md
# Power-Mode Controller with Timed Stop Wake

This block sets the power state of a small microcontroller. It tracks six operating modes. Four are run modes: high-speed and medium-speed, both clocked from the main oscillator, and two modes clocked from on-chip oscillators, one fast and one slow. The other two are wait and stop. From these it drives the CPU clock enable, the three oscillator enables and the flash enable. Software picks a run mode by writing three select bits. A wait request halts only the CPU clock. A stop request halts every oscillator and the flash.

Any interrupt request leaves wait at once. Leaving stop takes a four-phase timed sequence: power settling, flash restart, CPU clock restart and interrupt entry. At the end the block pulses a strobe that hands the CPU to the interrupt routine. All delays are counted in reference clock cycles. Microsecond figures become cycle counts through the parameter `REF_PER_US`. Phases that are measured in system-clock periods use the period of the run mode being restored.

Mode codes on `mode_o`: 0 = high-speed, 1 = medium-speed, 2 = fast on-chip, 3 = slow on-chip, 4 = wait, 5 = stop. Phase codes on `wake_phase_o`: 0 = no wake in progress, then 1 to 4 for the phases in order. The period p, in reference cycles, is 1 for mode 0, `MED_DIV` (8) for mode 1, `HOCO_DIV` (2) for mode 2 and `LOCO_DIV` (16) for mode 3. The oscillator start time is `MAIN_START` (40) for modes 0 and 1, `HOCO_START` (8) for mode 2 and `LOCO_START` (4) for mode 3.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset, mode_o is 0 and wake_phase_o is 0. cpu_clk_en_o, flash_en_o and loco_en_o are 1, main_osc_en_o follows main_on_i, and wake_done_o is 0.
- R2: In a run mode, a pulse on mode_wr_i selects the run mode from the select bits, and mode_o shows it one cycle later. With sel_onchip_i=1, sel_hs_i=1 gives mode 2 and sel_hs_i=0 gives mode 3. With sel_onchip_i=0, sel_div_i=1 gives mode 1 and sel_div_i=0 gives mode 0.
- R3: A mode write is ignored, and the current mode is kept, when its target source is switched off. Modes 0 and 1 need main_on_i=1 and mode 2 needs hs_on_i=1. Mode 3 is always accepted.
- R4: wait_req_i in a run mode gives mode 4 one cycle later. In wait, cpu_clk_en_o is 0, flash_en_o is 1, and the enable of the active oscillator stays 1.
- R5: In wait, irq_i returns mode_o to the run mode held before wait, one cycle later.
- R6: stop_req_i in a run mode gives mode 5 one cycle later. It wins over wait_req_i and mode_wr_i in the same cycle. In mode 5 with wake_phase_o at 0, every oscillator enable, cpu_clk_en_o and flash_en_o are 0.
- R7: irq_i in stop starts the wake. wake_phase_o steps through 1, 2, 3, 4 in that order, and phase 1 lasts PWR_US*REF_PER_US cycles (600).
- R8: Phase 2 lasts 12*p cycles, plus FLASH_US*REF_PER_US (120) when flash_slow_i is 1 at the cycle the wake starts. flash_en_o is 1 from phase 2 on.
- R9: Phase 3 lasts the start time of the restored source plus 6*p cycles, with only that source's oscillator enable on and the CPU clock off. Phase 4 lasts 20*p cycles with cpu_clk_en_o on.
- R10: wake_done_o is a one-cycle strobe exactly L1+L2+L3+L4 cycles after the edge that samples irq_i. During the strobe mode_o is still 5. One cycle later mode_o is the restored run mode, with cpu_clk_en_o and flash_en_o at 1.
- R11: irq_i in a run mode has no effect. While a wake is running, irq_i does not restart or stretch it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| main_on_i | input | 1 | Main oscillator is switched on |
| hs_on_i | input | 1 | Fast on-chip oscillator is switched on |
| mode_wr_i | input | 1 | Mode-select write strobe |
| sel_onchip_i | input | 1 | Select an on-chip oscillator as the source |
| sel_hs_i | input | 1 | Choose fast (1) or slow (0) on-chip oscillator |
| sel_div_i | input | 1 | Choose medium speed on the main oscillator |
| wait_req_i | input | 1 | Enter wait mode |
| stop_req_i | input | 1 | Enter stop mode |
| flash_slow_i | input | 1 | Stop flash too; adds the slow restart delay |
| irq_i | input | 1 | Any interrupt request |
| mode_o | output | 3 | Current mode code |
| wake_phase_o | output | 3 | Current wake phase (0 = none) |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| main_osc_en_o | output | 1 | Main oscillator enable |
| hoco_en_o | output | 1 | Fast on-chip oscillator enable |
| loco_en_o | output | 1 | Slow on-chip oscillator enable |
| flash_en_o | output | 1 | Flash enable |
| wake_done_o | output | 1 | Strobe: wake complete, interrupt vector taken |

## Verification
The stop wake is run from all four run modes. Mode 0 with a fast flash restart and mode 3 with a slow one isolate the per-period phases from the fixed microsecond terms. Mode 1 separates the period-scaled terms from the main-oscillator start time. Mode 2 catches a wrong period or start time for the fast on-chip source. In each run the cycles spent in every phase are counted separately, so an error in one phase length cannot be hidden by another. The irq is held high into phase 2 to expose any restart. Mode writes aimed at a switched-off source, a simultaneous stop/wait/write request, and a wait round trip exercise the run-side decisions.

// File: rtl/lpm_ctrl_pkg.sv
package lpm_ctrl_pkg;

    typedef enum logic [2:0] {
        M_HIGH = 3'd0,
        M_MED  = 3'd1,
        M_HOCO = 3'd2,
        M_LOCO = 3'd3,
        M_WAIT = 3'd4,
        M_STOP = 3'd5
    } mode_t;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WAIT = 2'd1,
        ST_STOP = 2'd2
    } st_t;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_PWR   = 3'd1,
        PH_FLASH = 3'd2,
        PH_CLK   = 3'd3,
        PH_IRQ   = 3'd4
    } phase_t;

    typedef enum logic [1:0] {
        SRC_MAIN = 2'd0,
        SRC_HOCO = 2'd1,
        SRC_LOCO = 2'd2
    } src_t;

    typedef struct packed {
        logic main;
        logic hoco;
        logic loco;
    } osc_en_t;

    typedef struct packed {
        logic onchip;
        logic hs;
        logic div;
    } sel_t;

    // Run mode named by the select bits
    function automatic mode_t decode_sel(sel_t s);
        if (s.onchip) return s.hs ? M_HOCO : M_LOCO;
        return s.div ? M_MED : M_HIGH;
    endfunction

    // Oscillator that clocks a run mode
    function automatic src_t mode_src(mode_t m);
        case (m)
            M_HIGH, M_MED: return SRC_MAIN;
            M_HOCO:        return SRC_HOCO;
            default:       return SRC_LOCO;
        endcase
    endfunction

    // Is a source available to be selected
    function automatic logic src_ok(src_t s, logic main_on, logic hs_on);
        case (s)
            SRC_MAIN: return main_on;
            SRC_HOCO: return hs_on;
            default:  return 1'b1;
        endcase
    endfunction

    function automatic osc_en_t src_onehot(src_t s);
        osc_en_t o;
        o      = '0;
        o.main = (s == SRC_MAIN);
        o.hoco = (s == SRC_HOCO);
        o.loco = (s == SRC_LOCO);
        return o;
    endfunction

endpackage

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
    import lpm_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   main_on_i,
    input  logic   hs_on_i,
    input  logic   mode_wr_i,
    input  sel_t   sel_i,
    input  logic   wait_req_i,
    input  logic   stop_req_i,
    input  logic   irq_i,
    input  logic   wake_busy_i,
    input  logic   wake_done_i,
    output st_t    st_o,
    output mode_t  run_mode_o,
    output mode_t  mode_o,
    output logic   wake_start_o
);

    st_t   st_q;
    mode_t run_q;
    mode_t tgt_c;
    logic  tgt_ok_c;

    always_comb begin
        tgt_c    = decode_sel(sel_i);
        tgt_ok_c = src_ok(mode_src(tgt_c), main_on_i, hs_on_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_RUN;
            run_q <= M_HIGH;
        end else begin
            case (st_q)
                ST_RUN: begin
                    if (stop_req_i)
                        st_q <= ST_STOP;
                    else if (wait_req_i)
                        st_q <= ST_WAIT;
                    else if (mode_wr_i && tgt_ok_c)
                        run_q <= tgt_c;
                end
                ST_WAIT: begin
                    if (irq_i) st_q <= ST_RUN;
                end
                ST_STOP: begin
                    if (wake_done_i) st_q <= ST_RUN;
                end
                default: st_q <= ST_RUN;
            endcase
        end
    end

    assign wake_start_o = (st_q == ST_STOP) && irq_i && !wake_busy_i && !wake_done_i;
    assign st_o         = st_q;
    assign run_mode_o   = run_q;

    always_comb begin
        case (st_q)
            ST_RUN:  mode_o = run_q;
            ST_WAIT: mode_o = M_WAIT;
            default: mode_o = M_STOP;
        endcase
    end

    // R3
    bad_sel_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && mode_wr_i && !stop_req_i && !wait_req_i &&
         !src_ok(mode_src(decode_sel(sel_i)), main_on_i, hs_on_i)) |=> $stable(run_q));

    // R5
    wait_return_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT && irq_i) |=> (st_q == ST_RUN && $stable(run_q)));

    // R6
    stop_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && stop_req_i) |=> (st_q == ST_STOP));

endmodule

// File: rtl/lpm_wake_seq.sv
module lpm_wake_seq
    import lpm_ctrl_pkg::*;
#(
    parameter int REF_PER_US = 4,
    parameter int PWR_US     = 150,
    parameter int FLASH_US   = 30,
    parameter int MED_DIV    = 8,
    parameter int HOCO_DIV   = 2,
    parameter int LOCO_DIV   = 16,
    parameter int MAIN_START = 40,
    parameter int HOCO_START = 8,
    parameter int LOCO_START = 4,
    parameter int CNT_W      = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    input  mode_t  run_mode_i,
    input  logic   flash_slow_i,
    output phase_t phase_o,
    output logic   done_o
);

    localparam int PWR_LEN    = PWR_US * REF_PER_US;
    localparam int FLASH_XTRA = FLASH_US * REF_PER_US;
    localparam int FLASH_CYC  = 12;
    localparam int CLK_CYC    = 6;
    localparam int IRQ_CYC    = 20;

    phase_t           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             slow_q;
    logic             done_q;

    int per_c;
    int start_c;
    int len_flash_c;
    int len_clk_c;
    int len_irq_c;

    always_comb begin
        case (run_mode_i)
            M_HIGH:  per_c = 1;
            M_MED:   per_c = MED_DIV;
            M_HOCO:  per_c = HOCO_DIV;
            default: per_c = LOCO_DIV;
        endcase
        case (mode_src(run_mode_i))
            SRC_MAIN: start_c = MAIN_START;
            SRC_HOCO: start_c = HOCO_START;
            default:  start_c = LOCO_START;
        endcase
        len_flash_c = FLASH_CYC * per_c + (slow_q ? FLASH_XTRA : 0);
        len_clk_c   = start_c + CLK_CYC * per_c;
        len_irq_c   = IRQ_CYC * per_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            slow_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (phase_q == PH_IDLE) begin
                if (start_i) begin
                    phase_q <= PH_PWR;
                    cnt_q   <= CNT_W'(PWR_LEN - 1);
                    slow_q  <= flash_slow_i;
                end
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else begin
                case (phase_q)
                    PH_PWR: begin
                        phase_q <= PH_FLASH;
                        cnt_q   <= CNT_W'(len_flash_c - 1);
                    end
                    PH_FLASH: begin
                        phase_q <= PH_CLK;
                        cnt_q   <= CNT_W'(len_clk_c - 1);
                    end
                    PH_CLK: begin
                        phase_q <= PH_IRQ;
                        cnt_q   <= CNT_W'(len_irq_c - 1);
                    end
                    default: begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end
                endcase
            end
        end
    end

    assign phase_o = phase_q;
    assign done_o  = done_q;

    // R7
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && cnt_q != '0) |=> $stable(phase_q));

    // R7
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PWR) |=> (phase_q inside {PH_PWR, PH_FLASH}));

    // R10
    done_after_irq_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ($past(phase_q) == PH_IRQ && phase_q == PH_IDLE));

    // R11
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |-> (phase_q == PH_IDLE && !done_q));

endmodule

// File: rtl/lpm_gate_dec.sv
module lpm_gate_dec
    import lpm_ctrl_pkg::*;
(
    input  st_t     st_i,
    input  mode_t   run_mode_i,
    input  phase_t  phase_i,
    input  logic    main_on_i,
    input  logic    hs_on_i,
    output osc_en_t osc_o,
    output logic    cpu_en_o,
    output logic    flash_en_o
);

    osc_en_t run_osc_c;
    osc_en_t src_osc_c;

    always_comb begin
        src_osc_c      = src_onehot(mode_src(run_mode_i));
        run_osc_c.main = main_on_i;
        run_osc_c.hoco = hs_on_i;
        run_osc_c.loco = 1'b1;
        run_osc_c      = run_osc_c | src_osc_c;
    end

    always_comb begin
        osc_o      = '0;
        cpu_en_o   = 1'b0;
        flash_en_o = 1'b0;
        case (st_i)
            ST_RUN: begin
                osc_o      = run_osc_c;
                cpu_en_o   = 1'b1;
                flash_en_o = 1'b1;
            end
            ST_WAIT: begin
                osc_o      = run_osc_c;
                flash_en_o = 1'b1;
            end
            default: begin
                case (phase_i)
                    PH_FLASH: flash_en_o = 1'b1;
                    PH_CLK: begin
                        flash_en_o = 1'b1;
                        osc_o      = src_osc_c;
                    end
                    PH_IRQ: begin
                        flash_en_o = 1'b1;
                        osc_o      = src_osc_c;
                        cpu_en_o   = 1'b1;
                    end
                    default: ;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_ctrl_pkg::*;
#(
    parameter int REF_PER_US = 4,
    parameter int PWR_US     = 150,
    parameter int FLASH_US   = 30,
    parameter int MED_DIV    = 8,
    parameter int HOCO_DIV   = 2,
    parameter int LOCO_DIV   = 16,
    parameter int MAIN_START = 40,
    parameter int HOCO_START = 8,
    parameter int LOCO_START = 4,
    parameter int CNT_W      = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       main_on_i,
    input  logic       hs_on_i,
    input  logic       mode_wr_i,
    input  logic       sel_onchip_i,
    input  logic       sel_hs_i,
    input  logic       sel_div_i,
    input  logic       wait_req_i,
    input  logic       stop_req_i,
    input  logic       flash_slow_i,
    input  logic       irq_i,
    output logic [2:0] mode_o,
    output logic [2:0] wake_phase_o,
    output logic       cpu_clk_en_o,
    output logic       main_osc_en_o,
    output logic       hoco_en_o,
    output logic       loco_en_o,
    output logic       flash_en_o,
    output logic       wake_done_o
);

    sel_t    sel;
    st_t     st;
    mode_t   run_mode;
    mode_t   mode;
    logic    wake_start;
    phase_t  phase;
    logic    wake_done;
    osc_en_t osc;
    logic    cpu_en;
    logic    flash_en;

    assign sel.onchip = sel_onchip_i;
    assign sel.hs     = sel_hs_i;
    assign sel.div    = sel_div_i;

    lpm_mode_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .main_on_i    (main_on_i),
        .hs_on_i      (hs_on_i),
        .mode_wr_i    (mode_wr_i),
        .sel_i        (sel),
        .wait_req_i   (wait_req_i),
        .stop_req_i   (stop_req_i),
        .irq_i        (irq_i),
        .wake_busy_i  (phase != PH_IDLE),
        .wake_done_i  (wake_done),
        .st_o         (st),
        .run_mode_o   (run_mode),
        .mode_o       (mode),
        .wake_start_o (wake_start)
    );

    lpm_wake_seq #(
        .REF_PER_US (REF_PER_US),
        .PWR_US     (PWR_US),
        .FLASH_US   (FLASH_US),
        .MED_DIV    (MED_DIV),
        .HOCO_DIV   (HOCO_DIV),
        .LOCO_DIV   (LOCO_DIV),
        .MAIN_START (MAIN_START),
        .HOCO_START (HOCO_START),
        .LOCO_START (LOCO_START),
        .CNT_W      (CNT_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_i      (wake_start),
        .run_mode_i   (run_mode),
        .flash_slow_i (flash_slow_i),
        .phase_o      (phase),
        .done_o       (wake_done)
    );

    lpm_gate_dec u_dec (
        .st_i       (st),
        .run_mode_i (run_mode),
        .phase_i    (phase),
        .main_on_i  (main_on_i),
        .hs_on_i    (hs_on_i),
        .osc_o      (osc),
        .cpu_en_o   (cpu_en),
        .flash_en_o (flash_en)
    );

    assign mode_o        = mode;
    assign wake_phase_o  = phase;
    assign cpu_clk_en_o  = cpu_en;
    assign main_osc_en_o = osc.main;
    assign hoco_en_o     = osc.hoco;
    assign loco_en_o     = osc.loco;
    assign flash_en_o    = flash_en;
    assign wake_done_o   = wake_done;

    // R6
    stop_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == M_STOP && phase == PH_IDLE) |->
        !(osc.main || osc.hoco || osc.loco || cpu_en || flash_en));

    // R4
    wait_cpu_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == M_WAIT) |-> (!cpu_en && flash_en));

    // R9
    clk_phase_cpu_off_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CLK) |-> (!cpu_en && $countones({osc.main, osc.hoco, osc.loco}) == 1));

    // R10
    wake_return_chk: assert property (@(posedge clk) disable iff (rst)
        wake_done |=> (mode == run_mode && cpu_en));

endmodule

// File: tb/lpm_ctrl_tb_top.sv
module lpm_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       main_on, hs_on, mode_wr, sel_onchip, sel_hs, sel_div;
    logic       wait_req, stop_req, flash_slow, irq;
    logic [2:0] mode, wake_phase;
    logic       cpu_en, main_en, hoco_en, loco_en, flash_en, wake_done;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    lpm_ctrl dut_i (
        .clk           (clk),
        .rst           (rst),
        .main_on_i     (main_on),
        .hs_on_i       (hs_on),
        .mode_wr_i     (mode_wr),
        .sel_onchip_i  (sel_onchip),
        .sel_hs_i      (sel_hs),
        .sel_div_i     (sel_div),
        .wait_req_i    (wait_req),
        .stop_req_i    (stop_req),
        .flash_slow_i  (flash_slow),
        .irq_i         (irq),
        .mode_o        (mode),
        .wake_phase_o  (wake_phase),
        .cpu_clk_en_o  (cpu_en),
        .main_osc_en_o (main_en),
        .hoco_en_o     (hoco_en),
        .loco_en_o     (loco_en),
        .flash_en_o    (flash_en),
        .wake_done_o   (wake_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int per_of(input int m);
        case (m)
            0: return 1;
            1: return 8;
            2: return 2;
            default: return 16;
        endcase
    endfunction

    function automatic int start_of(input int m);
        if (m < 2) return 40;
        if (m == 2) return 8;
        return 4;
    endfunction

    task automatic write_mode(input int m);
        @(negedge clk);
        sel_onchip = (m >= 2);
        sel_hs     = (m == 2);
        sel_div    = (m == 1);
        mode_wr    = 1'b1;
        @(negedge clk);
        mode_wr    = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        main_on = 1'b1; hs_on = 1'b1; mode_wr = 1'b0;
        sel_onchip = 1'b0; sel_hs = 1'b0; sel_div = 1'b0;
        wait_req = 1'b0; stop_req = 1'b0; flash_slow = 1'b0; irq = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(mode == 3'd0, "R1 mode", mode, 0);
        chk(wake_phase == 3'd0, "R1 phase", wake_phase, 0);
        chk({cpu_en, flash_en, loco_en, main_en} == 4'b1111, "R1 enables",
            {cpu_en, flash_en, loco_en, main_en}, 15);
        chk(wake_done == 1'b0, "R1 wake_done", wake_done, 0);
    endtask

    task automatic t_select;
        for (int m = 3; m >= 0; m--) begin
            write_mode(m);
            chk(mode == 3'(m), "R2 select", mode, m);
        end
    endtask

    task automatic t_bad_select;
        write_mode(1);
        hs_on = 1'b0;
        write_mode(2);
        chk(mode == 3'd1, "R3 hoco off", mode, 1);
        write_mode(3);
        chk(mode == 3'd3, "R3 loco always", mode, 3);
        main_on = 1'b0;
        write_mode(0);
        chk(mode == 3'd3, "R3 main off", mode, 3);
        main_on = 1'b1; hs_on = 1'b1;
        write_mode(0);
        chk(mode == 3'd0, "R3 main back on", mode, 0);
    endtask

    task automatic t_wait;
        write_mode(2);
        @(negedge clk); wait_req = 1'b1;
        @(negedge clk); wait_req = 1'b0;
        chk(mode == 3'd4, "R4 wait mode", mode, 4);
        chk(cpu_en == 1'b0 && flash_en && hoco_en, "R4 wait enables",
            {cpu_en, flash_en, hoco_en}, 3);
        repeat (3) @(negedge clk);
        chk(mode == 3'd4, "R4 wait held", mode, 4);
        irq = 1'b1;
        @(negedge clk); irq = 1'b0;
        chk(mode == 3'd2, "R5 wait return", mode, 2);
        chk(cpu_en == 1'b1, "R5 cpu back", cpu_en, 1);
    endtask

    task automatic t_irq_run;
        irq = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(mode == 3'd2 && wake_phase == 3'd0, "R11 irq in run", mode, 2);
        end
        irq = 1'b0;
    endtask

    task automatic t_wake(input int m, input bit slow, input bit prio);
        int cnt[5];
        int per, exp1, exp2, exp3, exp4, prev;
        bit seen3, seen4, done_seen;
        write_mode(m);
        flash_slow = slow;
        @(negedge clk);
        stop_req = 1'b1;
        if (prio) begin
            wait_req = 1'b1;
            sel_onchip = 1'b1; sel_hs = 1'b0; mode_wr = 1'b1;
        end
        @(negedge clk);
        stop_req = 1'b0; wait_req = 1'b0; mode_wr = 1'b0;
        chk(mode == 3'd5, prio ? "R6 stop priority" : "R6 stop mode", mode, 5);
        chk({main_en, hoco_en, loco_en, cpu_en, flash_en} == 5'b0, "R6 all off",
            {main_en, hoco_en, loco_en, cpu_en, flash_en}, 0);
        repeat (4) @(negedge clk);
        chk(mode == 3'd5 && wake_phase == 3'd0, "R6 stop held", wake_phase, 0);

        per  = per_of(m);
        exp1 = 600;
        exp2 = 12 * per + (slow ? 120 : 0);
        exp3 = start_of(m) + 6 * per;
        exp4 = 20 * per;
        foreach (cnt[k]) cnt[k] = 0;
        prev = 1; seen3 = 0; seen4 = 0; done_seen = 0;
        irq = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (wake_done) begin
                done_seen = 1;
                break;
            end
            cnt[wake_phase]++;
            if (int'(wake_phase) < prev || int'(wake_phase) > prev + 1) begin
                chk(0, "R7 phase order", wake_phase, prev);
            end
            prev = int'(wake_phase);
            if (wake_phase == 3'd2) irq = 1'b0;
            if (wake_phase == 3'd3 && !seen3) begin
                seen3 = 1;
                chk({main_en, hoco_en, loco_en} == {m < 2, m == 2, m == 3} && !cpu_en && flash_en,
                    "R9 clk phase enables", {main_en, hoco_en, loco_en, cpu_en},
                    {m < 2, m == 2, m == 3, 1'b0});
            end
            if (wake_phase == 3'd4 && !seen4) begin
                seen4 = 1;
                chk(cpu_en == 1'b1, "R9 irq phase cpu", cpu_en, 1);
            end
        end
        irq = 1'b0;
        chk(done_seen, "R10 strobe seen", done_seen, 1);
        chk(cnt[0] == 0, "R7 no idle gap", cnt[0], 0);
        chk(cnt[1] == exp1, "R7 phase1 len", cnt[1], exp1);
        chk(cnt[2] == exp2, "R8 phase2 len", cnt[2], exp2);
        chk(cnt[3] == exp3, "R9 phase3 len", cnt[3], exp3);
        chk(cnt[4] == exp4, "R9 phase4 len", cnt[4], exp4);
        chk(cnt[1] + cnt[2] + cnt[3] + cnt[4] == exp1 + exp2 + exp3 + exp4, "R10 total latency",
            cnt[1] + cnt[2] + cnt[3] + cnt[4], exp1 + exp2 + exp3 + exp4);
        chk(mode == 3'd5, "R10 mode during strobe", mode, 5);
        @(negedge clk);
        chk(wake_done == 1'b0, "R10 strobe one cycle", wake_done, 0);
        chk(mode == 3'(m), "R10 restored mode", mode, m);
        chk(cpu_en && flash_en, "R10 run enables", {cpu_en, flash_en}, 3);
        chk(wake_phase == 3'd0, "R11 no restart", wake_phase, 0);
    endtask

    initial begin
        t_reset();
        t_select();
        t_bad_select();
        t_wait();
        t_irq_run();
        t_wake(0, 1'b0, 1'b0);
        t_wake(3, 1'b1, 1'b0);
        t_wake(1, 1'b1, 1'b1);
        t_wake(2, 1'b0, 1'b0);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule